// File: doc/BRIEF.md
# Banked Cartridge Mapper with Scanline Interrupt

This block sits between an 8-bit CPU bus, a separate pattern-memory bus and the cartridge memories. It does not hold the program ROM, pattern ROM, work RAM or nametable storage. It turns bus addresses into physical offsets for those arrays and drives their enables. It also tells the nametable logic which mirroring arrangement applies, and it raises an interrupt request after a programmed number of scanlines.

The CPU programs the block with writes anywhere in 0x8000–0xFFFF. Address bits 14:13 select one of four register pairs. Address bit 0 picks the even or the odd member of the pair. Eight bank registers, R0 to R7, are loaded indirectly: an even write selects which register to load and also sets two banking modes, and an odd write supplies the value. Values are folded into the available bank count when they are stored.

CPU reads in 0x8000–0xFFFF are translated through four 8 KiB windows. Pattern reads in 0x0000–0x1FFF are translated through 1 KiB and 2 KiB windows. CPU accesses in 0x6000–0x7FFF go to the work RAM. All translation is combinational from the present address and the stored register state.

Top module: `banked_cart_mapper`

## Requirements
- R1: A write to an even address in 0x8000–0x9FFE stores data bits 2:0 as the target register index, bit 6 as the program mode and bit 7 as the pattern mode. All three take effect on the cycle after the write.
- R2: A write to an odd address in 0x8001–0x9FFF loads the bank register named by the most recent index. The new value is used for translation from the next cycle. No write outside this range changes a bank register.
- R3: For R6 and R7, the stored value is (data & 0x3F) modulo PRG_BANKS. For R0–R5, the stored value is data modulo CHR_BANKS.
- R4: A write to an even address in 0xA000–0xBFFE sets mirror_horiz to data bit 0 (0 = vertical, 1 = horizontal). Writes to odd addresses in that range leave it unchanged.
- R5: When cpu_rd is high and cpu_addr ≥ 0x8000, prg_rom_rd is high and prg_rom_addr = bank·8192 + cpu_addr[12:0]. The bank comes from window cpu_addr[14:13]. In mode 0 the windows hold R6, R7, PRG_BANKS−2 and PRG_BANKS−1. In mode 1 they hold PRG_BANKS−2, R7, R6 and PRG_BANKS−1.
- R6: When ppu_rd is high and ppu_addr < 0x2000, chr_rom_rd is high and chr_rom_addr = bank·1024 + ppu_addr[9:0]. Let h = ppu_addr[12] XOR pattern mode. When h = 0, the 4 KiB half is split into 2 KiB windows: bank = (Rn with bit 0 cleared) + ppu_addr[10], where n = ppu_addr[11]. When h = 1, bank = R(2 + ppu_addr[11:10]).
- R7: For a CPU read or write in 0x6000–0x7FFF, wram_en is high and wram_addr = cpu_addr − 0x6000. wram_we is high only for the write. Outside that range wram_en and wram_we are low.
- R8: A write to an even address in 0xC000–0xDFFE loads the reload value from the data byte. A write to an odd address in 0xC001–0xDFFF sets the scanline counter to zero, and that write cycle ignores any tick.
- R9: On each scanline_tick, a counter at zero is reloaded and any other value is decremented. If the result is zero while interrupts are enabled, irq_pending is high from the next cycle.
- R10: A write to an even address in 0xE000–0xFFFE disables the interrupt and clears irq_pending from the next cycle. A write to an odd address in 0xE001–0xFFFF enables it.
- R11: After a synchronous reset with rst_n low, all of the following are zero: the bank registers, the index, both modes, mirroring, the reload value, the counter, the enable and irq_pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr | input | 14 | Pattern-bus address |
| ppu_rd | input | 1 | Pattern-bus read strobe |
| scanline_tick | input | 1 | One-cycle pulse per scanline |
| prg_rom_addr | output | PRG_AW (18) | Program ROM byte offset |
| prg_rom_rd | output | 1 | Program ROM read enable |
| wram_addr | output | 13 | Work RAM byte offset |
| wram_en | output | 1 | Work RAM access enable |
| wram_we | output | 1 | Work RAM write enable |
| chr_rom_addr | output | CHR_AW (17) | Pattern ROM byte offset |
| chr_rom_rd | output | 1 | Pattern ROM read enable |
| mirror_horiz | output | 1 | Nametable mirroring, 1 = horizontal |
| irq_pending | output | 1 | Interrupt request level |

## Verification
Address translation and the work-RAM outputs depend only on the present address and the stored state, so they are due in the same cycle as the request. A register write is captured at the rising edge where cpu_wr is high, and its effect shows on the following cycle. irq_pending changes one cycle after the edge that samples a tick or a disable write. The bench drives inputs at the falling edge, updates its reference state at the rising edge, and compares every output 2 ns after each falling edge, so both sides always see the same sampled inputs.

// File: rtl/cart_pkg.sv
// Shared types for the banked cartridge mapper.
// Assumes control writes are decoded from address bits 15:13 and bit 0 only.
package cart_pkg;

    localparam int NUM_BANK_REGS = 8;

    // One-hot style strobes, one for each control write kind
    typedef struct packed {
        logic bank_sel;
        logic bank_data;
        logic mirror_set;
        logic irq_latch;
        logic irq_reload;
        logic irq_off;
        logic irq_on;
    } ctl_wr_s;

    // Turns a CPU write into the strobe for its register pair member
    function automatic ctl_wr_s decode_ctl_write(input logic wr,
                                                 input logic [2:0] hi,
                                                 input logic odd);
        ctl_wr_s s;
        s = '0;
        if (wr && hi[2]) begin
            unique case (hi[1:0])
                2'b00: if (odd) s.bank_data  = 1'b1; else s.bank_sel   = 1'b1;
                2'b01: if (!odd) s.mirror_set = 1'b1;
                2'b10: if (odd) s.irq_reload = 1'b1; else s.irq_latch  = 1'b1;
                default: if (odd) s.irq_on   = 1'b1; else s.irq_off    = 1'b1;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/cart_regfile.sv
// Bank register file: index/mode select, eight folded bank registers, mirroring.
// Assumes PRG_BANKS and CHR_BANKS are no larger than 256.
module cart_regfile
    import cart_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    parameter int CHR_BANKS = 128
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  ctl_wr_s                         strb,
    input  logic [7:0]                      wdata,
    output logic [NUM_BANK_REGS-1:0][7:0]   banks,
    output logic                            prg_mode,
    output logic                            chr_mode,
    output logic                            mirror_horiz
);

    logic [2:0] sel_q;
    logic [7:0] prg_fold;
    logic [7:0] chr_fold;

    // Fold the write data into each bank space
    assign prg_fold = 8'((32'(wdata[5:0])) % PRG_BANKS);
    assign chr_fold = 8'((32'(wdata)) % CHR_BANKS);

    // Index and mode capture on a bank-select write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            prg_mode <= 1'b0;
            chr_mode <= 1'b0;
        end else if (strb.bank_sel) begin
            sel_q    <= wdata[2:0];
            prg_mode <= wdata[6];
            chr_mode <= wdata[7];
        end
    end

    // Mirroring capture
    always_ff @(posedge clk) begin
        if (!rst_n)               mirror_horiz <= 1'b0;
        else if (strb.mirror_set) mirror_horiz <= wdata[0];
    end

    for (genvar i = 0; i < NUM_BANK_REGS; i++) begin : g_bank
        logic [7:0] fold_val;
        if (i >= 6) begin : g_prg
            assign fold_val = prg_fold;
        end else begin : g_chr
            assign fold_val = chr_fold;
        end
        // Load this register when it is the selected target
        always_ff @(posedge clk) begin
            if (!rst_n)                                   banks[i] <= '0;
            else if (strb.bank_data && sel_q == 3'(i))    banks[i] <= fold_val;
        end
    end

    // R1: a select write is reflected in the index on the next cycle
    p_sel_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        strb.bank_sel |=> sel_q == $past(wdata[2:0]));

    // R3: program bank registers never exceed the bank count
    p_prg_fold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(banks[6]) < PRG_BANKS) && (32'(banks[7]) < PRG_BANKS));

    // R4: odd writes in the mirroring range leave mirroring unchanged
    p_mirror_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !strb.mirror_set |=> $stable(mirror_horiz));

endmodule

// File: rtl/cart_irq.sv
// Scanline counter with reload value, enable and pending request.
// Assumes scanline_tick is a single-cycle pulse; a reload write beats a tick.
module cart_irq
    import cart_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_wr_s          strb,
    input  logic [CNT_W-1:0] wdata,
    input  logic             scanline_tick,
    output logic             irq_pending
);

    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             en_q;
    logic             tick_eff;

    // Counter value a tick would produce
    assign cnt_next = (cnt_q == '0) ? latch_q : cnt_q - 1'b1;
    assign tick_eff = scanline_tick && !strb.irq_reload;

    // Reload value capture
    always_ff @(posedge clk) begin
        if (!rst_n)              latch_q <= '0;
        else if (strb.irq_latch) latch_q <= wdata;
    end

    // Counter: forced to zero by a reload write, stepped by a tick
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (strb.irq_reload) cnt_q <= '0;
        else if (scanline_tick)   cnt_q <= cnt_next;
    end

    // Enable flag
    always_ff @(posedge clk) begin
        if (!rst_n)            en_q <= 1'b0;
        else if (strb.irq_off) en_q <= 1'b0;
        else if (strb.irq_on)  en_q <= 1'b1;
    end

    // Pending request: set on reaching zero while enabled, cleared by disable
    always_ff @(posedge clk) begin
        if (!rst_n)                                     irq_pending <= 1'b0;
        else if (strb.irq_off)                          irq_pending <= 1'b0;
        else if (tick_eff && cnt_next == '0 && en_q)    irq_pending <= 1'b1;
    end

    // R10: a disable write clears the request on the next cycle
    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        strb.irq_off |=> !irq_pending);

    // R9: a new request only follows a tick seen while enabled
    p_set_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pending) |-> ($past(en_q) && $past(scanline_tick)));

    // R8: a reload write leaves the counter at zero
    p_reload_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        strb.irq_reload |=> cnt_q == '0);

endmodule

// File: rtl/cart_xlate.sv
// Combinational window translation for the program and pattern buses.
// Assumes CHR_BANKS is a power of two so paired 2 KiB windows stay in range.
module cart_xlate
    import cart_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    parameter int CHR_BANKS = 128,
    localparam int PBW    = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
    localparam int CBW    = (CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1,
    localparam int PRG_AW = PBW + 13,
    localparam int CHR_AW = CBW + 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANK_REGS-1:0][7:0] banks,
    input  logic                          prg_mode,
    input  logic                          chr_mode,
    input  logic [14:0]                   cpu_off,
    input  logic [12:0]                   ppu_off,
    output logic [PRG_AW-1:0]             prg_addr,
    output logic [CHR_AW-1:0]             chr_addr
);

    localparam logic [PBW-1:0] LAST_BANK   = PBW'(PRG_BANKS - 1);
    localparam logic [PBW-1:0] SECOND_LAST = PBW'(PRG_BANKS - 2);

    logic [PBW-1:0] prg_bank;
    logic [CBW-1:0] pair_base;
    logic [CBW-1:0] chr_bank;
    logic [2:0]     one_k_idx;
    logic           big_half;

    // Program window selection by address bits 14:13 and mode
    always_comb begin
        unique case (cpu_off[14:13])
            2'b00:   prg_bank = prg_mode ? SECOND_LAST : banks[6][PBW-1:0];
            2'b01:   prg_bank = banks[7][PBW-1:0];
            2'b10:   prg_bank = prg_mode ? banks[6][PBW-1:0] : SECOND_LAST;
            default: prg_bank = LAST_BANK;
        endcase
    end

    assign prg_addr = {prg_bank, cpu_off[12:0]};

    // Pattern window selection: 2 KiB pairs in one half, 1 KiB slots in the other
    assign big_half  = !(ppu_off[12] ^ chr_mode);
    assign pair_base = ppu_off[11] ? banks[1][CBW-1:0] : banks[0][CBW-1:0];
    assign one_k_idx = {1'b0, ppu_off[11:10]} + 3'd2;

    always_comb begin
        if (big_half) chr_bank = {pair_base[CBW-1:1], ppu_off[10]};
        else          chr_bank = banks[one_k_idx][CBW-1:0];
    end

    assign chr_addr = {chr_bank, ppu_off[9:0]};

    // R5: the top program window always shows the last bank
    p_fixed_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_off[14:13] == 2'b11 |-> prg_addr[PRG_AW-1:13] == LAST_BANK);

    // R6: in the 2 KiB half, adjacent 1 KiB slots are an even/odd bank pair
    p_pair_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        big_half |-> chr_addr[10] == ppu_off[10]);

endmodule

// File: rtl/banked_cart_mapper.sv
// Top of the banked cartridge mapper: decodes CPU control writes, holds bank
// and interrupt state, and translates CPU and pattern-bus addresses.
// Assumes one-cycle cpu_wr strobes; memories and nametables live outside.
module banked_cart_mapper
    import cart_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    parameter int CHR_BANKS = 128,
    localparam int PBW    = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
    localparam int CBW    = (CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1,
    localparam int PRG_AW = PBW + 13,
    localparam int CHR_AW = CBW + 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [13:0]       ppu_addr,
    input  logic              ppu_rd,
    input  logic              scanline_tick,
    output logic [PRG_AW-1:0] prg_rom_addr,
    output logic              prg_rom_rd,
    output logic [12:0]       wram_addr,
    output logic              wram_en,
    output logic              wram_we,
    output logic [CHR_AW-1:0] chr_rom_addr,
    output logic              chr_rom_rd,
    output logic              mirror_horiz,
    output logic              irq_pending
);

    ctl_wr_s                         strb;
    logic [NUM_BANK_REGS-1:0][7:0]   banks;
    logic                            prg_mode;
    logic                            chr_mode;
    logic                            in_wram;

    // Control-write decode
    assign strb = decode_ctl_write(cpu_wr, cpu_addr[15:13], cpu_addr[0]);

    cart_regfile #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .strb         (strb),
        .wdata        (cpu_wdata),
        .banks        (banks),
        .prg_mode     (prg_mode),
        .chr_mode     (chr_mode),
        .mirror_horiz (mirror_horiz)
    );

    cart_irq #(.CNT_W(8)) irq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .strb          (strb),
        .wdata         (cpu_wdata),
        .scanline_tick (scanline_tick),
        .irq_pending   (irq_pending)
    );

    cart_xlate #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) xlate_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .banks    (banks),
        .prg_mode (prg_mode),
        .chr_mode (chr_mode),
        .cpu_off  (cpu_addr[14:0]),
        .ppu_off  (ppu_addr[12:0]),
        .prg_addr (prg_rom_addr),
        .chr_addr (chr_rom_addr)
    );

    // Read enables and work RAM routing
    assign prg_rom_rd = cpu_rd && cpu_addr[15];
    assign chr_rom_rd = ppu_rd && !ppu_addr[13];
    assign in_wram    = cpu_addr[15:13] == 3'b011;
    assign wram_en    = in_wram && (cpu_rd || cpu_wr);
    assign wram_we    = in_wram && cpu_wr;
    assign wram_addr  = cpu_addr[12:0];

    // R7: a work RAM write strobe never appears without the access enable
    p_wram_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wram_we |-> wram_en && !prg_rom_rd);

endmodule

// File: tb/banked_cart_mapper_tb.sv
`timescale 1ns/1ps
module banked_cart_mapper_tb_top;

    localparam int PRG_BANKS = 32;
    localparam int CHR_BANKS = 128;
    localparam int PRG_AW = $clog2(PRG_BANKS) + 13;
    localparam int CHR_AW = $clog2(CHR_BANKS) + 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic [7:0]        cpu_wdata = '0;
    logic              cpu_rd = 1'b0;
    logic              cpu_wr = 1'b0;
    logic [13:0]       ppu_addr = '0;
    logic              ppu_rd = 1'b0;
    logic              scanline_tick = 1'b0;
    logic [PRG_AW-1:0] prg_rom_addr;
    logic              prg_rom_rd;
    logic [12:0]       wram_addr;
    logic              wram_en;
    logic              wram_we;
    logic [CHR_AW-1:0] chr_rom_addr;
    logic              chr_rom_rd;
    logic              mirror_horiz;
    logic              irq_pending;

    always #4 clk = ~clk;

    banked_cart_mapper #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .ppu_rd(ppu_rd),
        .scanline_tick(scanline_tick), .prg_rom_addr(prg_rom_addr),
        .prg_rom_rd(prg_rom_rd), .wram_addr(wram_addr), .wram_en(wram_en),
        .wram_we(wram_we), .chr_rom_addr(chr_rom_addr), .chr_rom_rd(chr_rom_rd),
        .mirror_horiz(mirror_horiz), .irq_pending(irq_pending)
    );

    int errors = 0;
    int checks = 0;
    bit chk_on = 0;
    bit done = 0;

    // Reference state
    int m_bank[8];
    int m_sel, m_latch, m_cnt;
    bit m_pm, m_cm, m_mir, m_en, m_pend;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // Reference state update at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_bank[i]) m_bank[i] = 0;
            m_sel = 0; m_pm = 0; m_cm = 0; m_mir = 0;
            m_latch = 0; m_cnt = 0; m_en = 0; m_pend = 0;
        end else begin
            int nxt;
            bit reload, off, on;
            bit old_en;
            old_en = m_en;
            reload = 0; off = 0; on = 0;
            nxt = (m_cnt == 0) ? m_latch : m_cnt - 1;
            if (cpu_wr && cpu_addr >= 16'h8000) begin
                case (cpu_addr[14:13])
                    2'd0: if (!cpu_addr[0]) begin
                              m_sel = cpu_wdata & 7; m_pm = cpu_wdata[6]; m_cm = cpu_wdata[7];
                          end else if (m_sel >= 6) m_bank[m_sel] = (cpu_wdata & 8'h3F) % PRG_BANKS;
                          else m_bank[m_sel] = cpu_wdata % CHR_BANKS;
                    2'd1: if (!cpu_addr[0]) m_mir = cpu_wdata[0];
                    2'd2: if (!cpu_addr[0]) m_latch = cpu_wdata; else reload = 1;
                    default: if (!cpu_addr[0]) off = 1; else on = 1;
                endcase
            end
            if (reload) m_cnt = 0;
            else if (scanline_tick) m_cnt = nxt;
            if (off) m_pend = 0;
            else if (scanline_tick && !reload && nxt == 0 && old_en) m_pend = 1;
            if (off) m_en = 0; else if (on) m_en = 1;
        end
    end

    function automatic int exp_prg(input int a);
        int b;
        case ((a >> 13) & 3)
            0: b = m_pm ? PRG_BANKS - 2 : m_bank[6];
            1: b = m_bank[7];
            2: b = m_pm ? m_bank[6] : PRG_BANKS - 2;
            default: b = PRG_BANKS - 1;
        endcase
        return b * 8192 + (a & 16'h1FFF);
    endfunction

    function automatic int exp_chr(input int a);
        int b;
        int half;
        half = ((a >> 12) & 1) ^ int'(m_cm);
        if (half == 0) b = (m_bank[(a >> 11) & 1] & ~1) | ((a >> 10) & 1);
        else b = m_bank[2 + ((a >> 10) & 3)];
        return b * 1024 + (a & 16'h3FF);
    endfunction

    // Per-cycle comparison against the reference, away from the rising edge
    always @(negedge clk) begin
        if (chk_on && !done) begin
            bit in_w;
            #2;
            in_w = (cpu_addr >= 16'h6000) && (cpu_addr <= 16'h7FFF);
            chk("R5 prg_rd", prg_rom_rd, cpu_rd && cpu_addr >= 16'h8000);
            if (cpu_rd && cpu_addr >= 16'h8000) chk("R5 prg_addr", prg_rom_addr, exp_prg(cpu_addr));
            chk("R6 chr_rd", chr_rom_rd, ppu_rd && ppu_addr < 14'h2000);
            if (ppu_rd && ppu_addr < 14'h2000) chk("R6 chr_addr", chr_rom_addr, exp_chr(ppu_addr));
            chk("R7 wram_en", wram_en, in_w && (cpu_rd || cpu_wr));
            chk("R7 wram_we", wram_we, in_w && cpu_wr);
            if (in_w) chk("R7 wram_addr", wram_addr, cpu_addr - 16'h6000);
            chk("R4 mirror", mirror_horiz, m_mir);
            chk("R9 irq", irq_pending, m_pend);
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
        @(negedge clk); cpu_wr = 0; cpu_addr = 16'h0000;
    endtask

    task automatic rd_prg(input logic [15:0] a, input int exp, input string tag);
        @(negedge clk); cpu_addr = a; cpu_rd = 1;
        #2 chk(tag, prg_rom_addr, exp);
        @(negedge clk); cpu_rd = 0;
    endtask

    task automatic rd_chr(input logic [13:0] a, input int exp, input string tag);
        @(negedge clk); ppu_addr = a; ppu_rd = 1;
        #2 chk(tag, chr_rom_addr, exp);
        @(negedge clk); ppu_rd = 0;
    endtask

    task automatic tick();
        @(negedge clk); scanline_tick = 1;
        @(negedge clk); scanline_tick = 0;
    endtask

    task automatic set_bank(input int idx, input logic [7:0] v, input logic [7:0] modes);
        wr(16'h8000, modes | 8'(idx));
        wr(16'h8001, v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; chk_on = 1;
        #2;
        chk("R11 irq after reset", irq_pending, 0);
        chk("R11 mirror after reset", mirror_horiz, 0);
        rd_prg(16'h8000, 0, "R11 bank regs zero");
        rd_prg(16'hE000, 31 * 8192, "R5 last window");
        rd_prg(16'hC000, 30 * 8192, "R5 second-last window mode 0");

        // R2: indirect loads of R6 and R7
        set_bank(6, 8'd5, 8'h00);
        set_bank(7, 8'd9, 8'h00);
        rd_prg(16'h8123, 5 * 8192 + 16'h123, "R2 R6 window");
        rd_prg(16'hA010, 9 * 8192 + 16, "R2 R7 window");
        wr(16'hA001, 8'd3);  // odd mirroring-range write: no bank change
        rd_prg(16'h8000, 5 * 8192, "R2 untouched by other writes");

        // R1: program mode 1 swaps R6 and the second-last bank
        wr(16'h8000, 8'h46);
        rd_prg(16'h8000, 30 * 8192, "R1 mode1 low window");
        rd_prg(16'hC001, 5 * 8192 + 1, "R1 mode1 R6 moved");

        // R3: folding
        wr(16'h8001, 8'hFF);
        rd_prg(16'hC000, 31 * 8192, "R3 R6 masked and folded");
        set_bank(7, 8'h50, 8'h40);
        rd_prg(16'hA000, 16 * 8192, "R3 R7 masked");

        // Pattern banks, mode 0
        set_bank(0, 8'h0B, 8'h00);
        set_bank(1, 8'h20, 8'h00);
        set_bank(2, 8'h85, 8'h00);
        set_bank(3, 8'd41, 8'h00);
        set_bank(4, 8'd42, 8'h00);
        set_bank(5, 8'd200, 8'h00);
        rd_chr(14'h0000, 10 * 1024, "R6 pair even slot");
        rd_chr(14'h0400, 11 * 1024, "R6 pair odd slot");
        rd_chr(14'h0812, 32 * 1024 + 16'h12, "R6 second pair");
        rd_chr(14'h0C00, 33 * 1024, "R6 second pair odd");
        rd_chr(14'h1000, 5 * 1024, "R3 pattern fold");
        rd_chr(14'h1C05, 72 * 1024 + 5, "R6 last 1K slot");
        // R1: pattern mode 1 swaps the halves
        wr(16'h8000, 8'h80);
        rd_chr(14'h0000, 5 * 1024, "R1 pattern mode1 low half");
        rd_chr(14'h1400, 11 * 1024, "R1 pattern mode1 pair");
        rd_chr(14'h1FFF, 33 * 1024 + 1023, "R6 mode1 top byte");

        // R4: mirroring
        wr(16'hA000, 8'h01);
        #2 chk("R4 horizontal", mirror_horiz, 1);
        wr(16'hA001, 8'h00);
        #2 chk("R4 odd ignored", mirror_horiz, 1);
        wr(16'hBFFE, 8'h00);
        #2 chk("R4 vertical", mirror_horiz, 0);

        // R7: work RAM
        @(negedge clk); cpu_addr = 16'h6000; cpu_rd = 1;
        #2 chk("R7 read enable", wram_en, 1); chk("R7 read no we", wram_we, 0);
        @(negedge clk); cpu_addr = 16'h5FFF;
        #2 chk("R7 below range", wram_en, 0);
        @(negedge clk); cpu_rd = 0; cpu_addr = 16'h7ABC; cpu_wr = 1; cpu_wdata = 8'h55;
        #2 chk("R7 write offset", wram_addr, 16'h1ABC); chk("R7 write we", wram_we, 1);
        @(negedge clk); cpu_wr = 0; cpu_addr = 16'h0000;

        // R8/R9: reload value 3, counter cleared, enabled
        wr(16'hC000, 8'd3);
        wr(16'hC001, 8'd0);
        wr(16'hE001, 8'd0);
        tick(); tick(); tick();
        #2 chk("R9 not yet zero", irq_pending, 0);
        tick();
        #2 chk("R9 reached zero", irq_pending, 1);
        // R10: disable clears
        wr(16'hE000, 8'd0);
        #2 chk("R10 disable clears", irq_pending, 0);
        repeat (5) tick();
        #2 chk("R10 disabled stays low", irq_pending, 0);
        // R8: reload value 0 fires on every tick once enabled
        wr(16'hC000, 8'd0);
        wr(16'hC001, 8'd0);
        wr(16'hE001, 8'd0);
        tick();
        #2 chk("R8 zero reload value", irq_pending, 1);
        wr(16'hE000, 8'd0);
        // R8: reload forces counter to zero mid-count
        wr(16'hC000, 8'd5);
        wr(16'hC001, 8'd0);
        wr(16'hE001, 8'd0);
        tick(); tick();
        wr(16'hC001, 8'd0);
        repeat (5) tick();
        #2 chk("R8 reload restarts count", irq_pending, 0);
        tick();
        #2 chk("R8 reload then count", irq_pending, 1);

        // R11: reset mid-run
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        #2 chk("R11 irq cleared", irq_pending, 0);
        chk("R11 mirror cleared", mirror_horiz, 0);
        rd_chr(14'h1000, 0, "R11 pattern banks zero");

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule